// File: doc/BRIEF.md
# Supervisory Reset Controller with Reset-Cause Flag

This block sequences the reset of a supply domain. It watches four things: a lockout input that says the supply is too low to run, a monitored-voltage-low input, a vector of regulator enables, and two independent watchdog timeout strobes. It drives an active-low, registered reset output. It also drives a cause flag as an open-drain pull-down enable. When the pull-down is active, an external pull-up reads low, which marks a reset forced by the second watchdog. Any other reset leaves the pin released, so it reads high.

After reset the processor reads the flag to learn why it was restarted. A released flag together with a failed memory signature means power was lost. A released flag with a good signature means the first watchdog fired. A pulled-low flag means the second watchdog fired. A window timer starts when the reset output is released and returns the flag to the released state when it expires. A first-watchdog or low-voltage reset that lands inside that window leaves the flag frozen. The power-on delay, both reset pulse lengths and the window length are all parameters counted in clock cycles.

Top module: `supv_rst_ctrl`

## Requirements
- R1: While `uvlo_i` is 1, from the next clock edge `rst_out_n` is 0, `cause_pd_o` is 0 and all timers are cleared.
- R2: When `uvlo_i` falls, `rst_out_n` stays 0 for exactly `POR_CYC` cycles and then rises; `cause_pd_o` is 0 after power-on reset.
- R3: After power-on reset the block stays in standby, with `rst_out_n` high and all watchdog or voltage inputs ignored, until every bit of `reg_en_i` is 1. It then becomes active. When every enable bit returns to 0 it goes back to standby.
- R4: When active, a `wd1_to_i` strobe or `vmon_low_i` high drives `rst_out_n` low for exactly `RP1_CYC` cycles. Outside the clear window this sets `cause_pd_o` to 0.
- R5: When active, a `wd2_to_i` strobe drives `rst_out_n` low for exactly `RP2_CYC` cycles, and from the next edge on `cause_pd_o` is 1.
- R6: When `wd1_to_i` and `wd2_to_i` arrive in the same cycle, the second-watchdog action of R5 is taken.
- R7: After a reset that updated the flag, `cause_pd_o` returns to 0 exactly `CLR_CYC` cycles after the rising edge of `rst_out_n`.
- R8: A first-watchdog or low-voltage reset that starts inside the clear window leaves `cause_pd_o` unchanged. Its release does not re-arm the window, so the flag stays at its value.
- R9: A reset that starts inside the clear window cancels the timer. A second-watchdog reset arms a fresh full window at its own release.
- R10: Strobes arriving while a reset pulse is running are ignored, and the pulse length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| uvlo_i | input | 1 | 1 while the supply is below the lockout level |
| vmon_low_i | input | 1 | 1 while the monitored voltage is below threshold |
| reg_en_i | input | EN_N | Regulator enable inputs |
| wd1_to_i | input | 1 | First watchdog timeout, single-cycle strobe |
| wd2_to_i | input | 1 | Second watchdog timeout, single-cycle strobe |
| rst_out_n | output | 1 | Active-low reset output |
| cause_pd_o | output | 1 | Cause flag pull-down enable (1 = flag reads low) |

## Verification
Two functions can fall in the same cycle: a new reset request and the clear-window timer, which either expires or is re-armed. They collide when a watchdog strobe is driven a few cycles after a release, while the window is still open. Both watchdogs are also driven in one cycle. The outcome is judged at the ports. The bench checks whether the flag holds or changes, and it measures the pulse width in cycles. It then counts the cycles from the next release to the flag clearing. That count must equal the full window, or the flag must stay frozen when the window was not re-armed.

// File: rtl/supv_rst_ctrl.sv
module supv_rst_ctrl #(
  parameter int EN_N    = 2,
  parameter int POR_CYC = 16,
  parameter int RP1_CYC = 8,
  parameter int RP2_CYC = 12,
  parameter int CLR_CYC = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uvlo_i,
  input  logic            vmon_low_i,
  input  logic [EN_N-1:0] reg_en_i,
  input  logic            wd1_to_i,
  input  logic            wd2_to_i,
  output logic            rst_out_n,
  output logic            cause_pd_o
);

  localparam int CMAX_A = (POR_CYC > RP1_CYC) ? POR_CYC : RP1_CYC;
  localparam int CMAX   = (CMAX_A > RP2_CYC) ? CMAX_A : RP2_CYC;
  localparam int CW     = $clog2(CMAX + 1);
  localparam int WW     = $clog2(CLR_CYC + 1);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] RP1_LAST = CW'(RP1_CYC - 1);
  localparam logic [CW-1:0] RP2_LAST = CW'(RP2_CYC - 1);
  localparam logic [WW-1:0] CLR_LAST = WW'(CLR_CYC - 1);

  typedef enum logic [2:0] {
    S_OFF  = 3'd0,
    S_POR  = 3'd1,
    S_STBY = 3'd2,
    S_ACT  = 3'd3,
    S_RP1  = 3'd4,
    S_RP2  = 3'd5
  } st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          win;
  logic          upd;

  wire all_on  = &reg_en_i;
  wire all_off = ~|reg_en_i;
  wire timed   = (st_n == S_POR) || (st_n == S_RP1) || (st_n == S_RP2);

  always_comb begin
    st_n = st;
    if (uvlo_i) st_n = S_OFF;
    else begin
      case (st)
        S_OFF:  st_n = S_POR;
        S_POR:  if (cnt == POR_LAST) st_n = S_STBY;
        S_STBY: if (all_on) st_n = S_ACT;
        S_ACT: begin
          if (wd2_to_i)                      st_n = S_RP2;
          else if (wd1_to_i || vmon_low_i)   st_n = S_RP1;
          else if (all_off)                  st_n = S_STBY;
        end
        S_RP1:  if (cnt == RP1_LAST) st_n = S_ACT;
        S_RP2:  if (cnt == RP2_LAST) st_n = S_ACT;
        default: st_n = S_OFF;
      endcase
    end
  end

  wire rel_nxt = (st_n == S_STBY) || (st_n == S_ACT);
  wire enter2  = (st == S_ACT) && (st_n == S_RP2);
  wire enter1  = (st == S_ACT) && (st_n == S_RP1);
  wire por_end = (st == S_POR) && (st_n == S_STBY);
  wire rise    = !rst_out_n && rel_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      cnt       <= '0;
      rst_out_n <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= (st_n != st || !timed) ? '0 : cnt + 1'b1;
      rst_out_n <= rel_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_pd_o <= 1'b0;
      win        <= 1'b0;
      wcnt       <= '0;
      upd        <= 1'b0;
    end else if (uvlo_i) begin
      cause_pd_o <= 1'b0;
      win        <= 1'b0;
      wcnt       <= '0;
      upd        <= 1'b0;
    end else if (enter2) begin
      cause_pd_o <= 1'b1;
      upd        <= 1'b1;
      win        <= 1'b0;
    end else if (enter1) begin
      if (!win) cause_pd_o <= 1'b0;
      upd <= !win;
      win <= 1'b0;
    end else if (st == S_OFF) begin
      upd <= 1'b1;
    end else if (rise) begin
      if (por_end) cause_pd_o <= 1'b0;
      win  <= upd;
      wcnt <= '0;
    end else if (win) begin
      if (wcnt == CLR_LAST) begin
        win        <= 1'b0;
        cause_pd_o <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

endmodule

module supv_rst_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uvlo_i,
  input logic       vmon_low_i,
  input logic       wd1_to_i,
  input logic       wd2_to_i,
  input logic       rst_out_n,
  input logic       cause_pd_o,
  input logic [2:0] st,
  input logic       win
);
  localparam logic [2:0] C_ACT = 3'd3;
  localparam logic [2:0] C_RP1 = 3'd4;
  localparam logic [2:0] C_RP2 = 3'd5;

  a_r1_lockout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (!rst_out_n && !cause_pd_o));

  a_r5_wd2_pulls_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ACT && wd2_to_i && !uvlo_i) |=> (cause_pd_o && !rst_out_n));

  a_r6_wd2_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ACT && wd2_to_i && wd1_to_i && !uvlo_i) |=> (st == C_RP2));

  a_r8_window_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ACT && win && !wd2_to_i && (wd1_to_i || vmon_low_i) && !uvlo_i)
      |=> $stable(cause_pd_o));

  a_r4_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RP1 || st == C_RP2) |-> !rst_out_n);

  a_r3_active_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ACT) |-> rst_out_n);
endmodule

bind supv_rst_ctrl supv_rst_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i), .vmon_low_i(vmon_low_i),
  .wd1_to_i(wd1_to_i), .wd2_to_i(wd2_to_i), .rst_out_n(rst_out_n),
  .cause_pd_o(cause_pd_o), .st(st), .win(win)
);

// File: tb/supv_rst_ctrl_bench.sv
module supv_rst_ctrl_bench;
  localparam int POR = 16, RP1 = 8, RP2 = 12, CLR = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b1, vmon = 1'b0, wd1 = 1'b0, wd2 = 1'b0;
  logic [1:0] en = 2'b00;
  logic rst_out_n, cause_pd;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  supv_rst_ctrl #(.EN_N(2), .POR_CYC(POR), .RP1_CYC(RP1), .RP2_CYC(RP2), .CLR_CYC(CLR))
    u_supv_rst_ctrl (.clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .vmon_low_i(vmon),
      .reg_en_i(en), .wd1_to_i(wd1), .wd2_to_i(wd2), .rst_out_n(rst_out_n),
      .cause_pd_o(cause_pd));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (!rst_out_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse(input logic a1, input logic a2, input logic av, output int n);
    @(negedge clk); wd1 = a1; wd2 = a2; vmon = av;
    @(negedge clk); wd1 = 0; wd2 = 0; vmon = 0;
    low_len(n);
  endtask

  task automatic flag_len(output int n);
    n = 0;
    while (cause_pd && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    cyc(3);
    chk("R1 reset rst_out_n", rst_out_n, 0);
    chk("R1 reset cause_pd", cause_pd, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 lockout rst_out_n", rst_out_n, 0);
  endtask

  task automatic t_por;
    int n;
    uvlo = 1'b0;
    @(negedge clk);
    low_len(n);
    chk("R2 POR length", n, POR);
    chk("R2 flag after POR", cause_pd, 0);
  endtask

  task automatic t_standby;
    int n;
    en = 2'b01;
    @(negedge clk); wd2 = 1;
    @(negedge clk); wd2 = 0;
    cyc(3);
    chk("R3 standby ignores wd2 rst", rst_out_n, 1);
    chk("R3 standby ignores wd2 flag", cause_pd, 0);
    en = 2'b11;
    cyc(2);
    pulse(1, 0, 0, n);
    chk("R3 active after all enables", n, RP1);
    en = 2'b00;
    cyc(2);
    @(negedge clk); wd1 = 1;
    @(negedge clk); wd1 = 0;
    cyc(3);
    chk("R3 back in standby ignores wd1", rst_out_n, 1);
    en = 2'b11;
    cyc(2);
  endtask

  task automatic t_wd1_vmon;
    int n;
    pulse(1, 0, 0, n);
    chk("R4 wd1 pulse length", n, RP1);
    chk("R4 wd1 flag", cause_pd, 0);
    pulse(0, 0, 1, n);
    chk("R4 vmon pulse length", n, RP1);
  endtask

  task automatic t_wd2;
    int n;
    pulse(0, 1, 0, n);
    chk("R5 wd2 pulse length", n, RP2);
    chk("R5 wd2 flag low", cause_pd, 1);
    flag_len(n);
    chk("R7 clear window", n, CLR);
  endtask

  task automatic t_both;
    int n;
    pulse(1, 1, 0, n);
    chk("R6 both strobes length", n, RP2);
    chk("R6 both strobes flag", cause_pd, 1);
    flag_len(n);
  endtask

  task automatic t_frozen;
    int n;
    pulse(0, 1, 0, n);
    cyc(5);
    pulse(1, 0, 0, n);
    chk("R8 in-window wd1 length", n, RP1);
    chk("R8 in-window wd1 flag held", cause_pd, 1);
    cyc(CLR + 10);
    chk("R8 no re-arm, flag stays", cause_pd, 1);
    pulse(1, 0, 0, n);
    chk("R4 wd1 outside window updates", cause_pd, 0);
    cyc(CLR + 2);
  endtask

  task automatic t_cancel;
    int n;
    pulse(0, 1, 0, n);
    cyc(10);
    pulse(0, 1, 0, n);
    chk("R9 second wd2 flag", cause_pd, 1);
    flag_len(n);
    chk("R9 fresh full window", n, CLR);
  endtask

  task automatic t_ignore;
    int n;
    @(negedge clk); wd1 = 1;
    @(negedge clk); wd1 = 0;
    n = 1;
    cyc(2); n += 2;
    wd2 = 1;
    @(negedge clk); wd2 = 0; n++;
    while (!rst_out_n && n < 1000) begin n++; @(negedge clk); end
    chk("R10 strobe during pulse length", n - 1, RP1);
    chk("R10 strobe during pulse flag", cause_pd, 0);
    cyc(CLR + 2);
  endtask

  task automatic t_uvlo;
    int n;
    pulse(0, 1, 0, n);
    chk("R1 setup flag low", cause_pd, 1);
    uvlo = 1'b1;
    @(negedge clk);
    chk("R1 lockout rst_out_n", rst_out_n, 0);
    chk("R1 lockout flag", cause_pd, 0);
    cyc(5);
    uvlo = 1'b0;
    @(negedge clk);
    low_len(n);
    chk("R2 POR after lockout", n, POR);
    chk("R2 flag after lockout", cause_pd, 0);
  endtask

  initial begin
    t_reset();
    t_por();
    t_standby();
    t_wd1_vmon();
    t_wd2();
    t_both();
    t_frozen();
    t_cancel();
    t_ignore();
    t_uvlo();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule